// File: doc/BRIEF.md
# Two-Wire Serial Interface Control Unit

This block is the software-facing half of a two-wire (I2C-style) serial engine. Software reads and writes one 8-bit control register over a simple register bus and signals data-register writes with a strobe. The block holds the handshake flag that stops the byte-level engine between jobs. It turns software start and stop requests into engine commands, and it gates acknowledge generation, the bus output enables and a level interrupt.

The byte-level engine, which is modelled by the testbench, reports back when a job is done, when a STOP it was asked for has gone out, and whether the bus is free or a STOP has been seen. It also reports receive events: own address matched, general call received, or data byte received. While the handshake flag is up, the block asks the engine to hold SCL low. When software writes a one to the flag, the block emits a one-cycle go pulse that lets the engine continue.

Top module: `twi_ctrl_unit`

## Requirements
- R1: After reset the control register reads 0x00, and irq, bus_oe, scl_hold, go, start_go, stop_req, slave_rst and ack_drive are all low.
- R2: The readback layout of `ctl_rdata`, from bit 7 down to bit 0, is: done flag, ack enable, start request, stop request, write collision, interface enable, reserved, interrupt enable. Writes load bits 6, 5, 4, 2 and 0 from `ctl_wdata`. Writes never change bit 3, and bit 1 always reads 0.
- R3: A `eng_done` pulse while the interface is enabled sets the done flag (bit 7) on the next clock. The flag stays set until software clears it, and writing 0 to bit 7 leaves it set.
- R4: A control write with bit 7 = 1 while the flag is set clears the flag on the next clock, and `go` is high for exactly that one following cycle. If `eng_done` sets the flag in the same cycle, the set wins: the flag stays 1 and no `go` pulse is produced.
- R5: `scl_hold` is high exactly while the done flag is set and the interface is enabled.
- R6: A `dat_wr` strobe while the flag is clear sets the write-collision bit (bit 3). A `dat_wr` strobe while the flag is set clears it.
- R7: When the start request bit is set and the bus is free, `start_go` pulses high in the first cycle after the write. If the bus is busy, the block waits, and `start_go` goes high only in the cycle in which `bus_stop_seen` is high. Only one `start_go` is produced per request, even while the start bit remains set.
- R8: In master mode (`eng_master` = 1), a set stop bit drives `stop_req` high. The stop bit and `stop_req` stay high until an `eng_stop_done` pulse, after which both clear on the next clock.
- R9: In slave mode (`eng_master` = 0), a set stop bit produces no `stop_req`. Instead, `slave_rst` is high for one cycle, and the stop bit reads 0 from the next clock onward.
- R10: `ack_drive` is high only when ack enable (bit 6) is set and the interface is enabled, and one of the following holds: `ev_own_addr` is high, `ev_gen_call` is high together with `gc_enable`, or `ev_byte_rx` is high.
- R11: With interface enable (bit 2) clear, `bus_oe` is low, and `eng_done`, receive events and start requests have no effect: the flag stays clear, and `ack_drive` and `start_go` stay low.
- R12: `irq` is high exactly when the done flag, the interrupt-enable bit (bit 0) and the `glb_ie` input are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register readback |
| dat_wr | input | 1 | Data register write strobe |
| glb_ie | input | 1 | Global interrupt enable |
| eng_done | input | 1 | Engine finished its current job (pulse) |
| eng_stop_done | input | 1 | Engine has executed a STOP (pulse) |
| eng_master | input | 1 | Engine is in master mode |
| bus_free | input | 1 | Bus is idle |
| bus_stop_seen | input | 1 | A STOP was detected on the bus (pulse) |
| ev_own_addr | input | 1 | Own slave address received |
| ev_gen_call | input | 1 | General call received |
| gc_enable | input | 1 | General-call recognition enabled |
| ev_byte_rx | input | 1 | Data byte received in a receiver mode |
| go | output | 1 | One-cycle release pulse to the engine |
| scl_hold | output | 1 | Stretch SCL low |
| bus_oe | output | 1 | SDA/SCL output enable (low = high impedance) |
| start_go | output | 1 | Issue START now |
| stop_req | output | 1 | Issue STOP (master mode) |
| slave_rst | output | 1 | Return engine to unaddressed slave, lines released |
| ack_drive | output | 1 | Drive ACK for the current event |
| irq | output | 1 | Level interrupt |

## Verification
The bench writes a one to the flag in the same cycle that the engine reports a done job. A design that let software win there would drop a job, and the flag and `go` would both show it. It leaves the start bit set after a START has been issued. A design without a one-shot would keep pulsing `start_go`. It also holds the bus busy and then raises `bus_free` before any STOP is seen, to catch a design that starts too early. For stop requests in slave mode it checks that `stop_req` stays low and that the stop bit clears by itself; a design that shared the master path would leave the bit stuck. A table of acknowledge cases covers a general call without recognition enabled, and the enable-off tests confirm that engine events are ignored.

// File: rtl/twi_ctrl_pkg.sv
package twi_ctrl_pkg;
   localparam int unsigned CTL_W  = 8;
   localparam int unsigned B_FLAG = 7;
   localparam int unsigned B_ACK  = 6;
   localparam int unsigned B_STA  = 5;
   localparam int unsigned B_STO  = 4;
   localparam int unsigned B_WCOL = 3;
   localparam int unsigned B_EN   = 2;
   localparam int unsigned B_RSV  = 1;
   localparam int unsigned B_IE   = 0;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WAIT   = 2'd1,
      ST_ISSUED = 2'd2
   } sta_state_t;
endpackage

// File: rtl/twi_flag_unit.sv
module twi_flag_unit #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic hw_done,
   input  logic clr_wr,
   input  logic dat_wr,
   output logic flag_q,
   output logic wcol_q,
   output logic go_q
);
   logic set_ev;
   logic clr_ev;

   assign set_ev = en & hw_done;

   generate
      if (SET_WINS) begin : g_set_wins
         assign clr_ev = clr_wr & flag_q & ~set_ev;
      end else begin : g_clr_wins
         assign clr_ev = clr_wr & flag_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         wcol_q <= 1'b0;
         go_q   <= 1'b0;
      end else begin
         if (clr_ev)      flag_q <= 1'b0;
         else if (set_ev) flag_q <= 1'b1;
         if (dat_wr)      wcol_q <= ~flag_q;
         go_q <= clr_ev;
      end
   end

   assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && hw_done && !clr_wr) |=> flag_q);
   assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && flag_q && !(en && hw_done)) |=> (!flag_q && go_q));
   assert_go_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      go_q |=> !go_q);
   assert_ignore_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr_wr) |=> $stable(flag_q));
   assert_collision_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && !flag_q) |=> wcol_q);
endmodule

// File: rtl/twi_cmd_unit.sv
module twi_cmd_unit
   import twi_ctrl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic reg_wr,
   input  logic wr_sta,
   input  logic wr_sto,
   input  logic bus_free,
   input  logic bus_stop_seen,
   input  logic eng_master,
   input  logic eng_stop_done,
   output logic sta_q,
   output logic sto_q,
   output logic start_go,
   output logic stop_req,
   output logic slave_rst
);
   sta_state_t st_q;
   sta_state_t st_d;

   always_comb begin
      st_d     = st_q;
      start_go = 1'b0;
      if (!en || !sta_q) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (bus_free) begin
                  start_go = 1'b1;
                  st_d     = ST_ISSUED;
               end else begin
                  st_d = ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (bus_stop_seen) begin
                  start_go = 1'b1;
                  st_d     = ST_ISSUED;
               end
            end
            default: st_d = ST_ISSUED;
         endcase
      end
   end

   assign stop_req  = sto_q & en & eng_master;
   assign slave_rst = sto_q & en & ~eng_master;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         sta_q <= 1'b0;
         sto_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (reg_wr) begin
            sta_q <= wr_sta;
            sto_q <= wr_sto;
         end else if (slave_rst || (stop_req && eng_stop_done)) begin
            sto_q <= 1'b0;
         end
      end
   end

   assert_start_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_go |=> !start_go);
   assert_mstop_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && eng_stop_done && !reg_wr) |=> !sto_q);
   assert_mstop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !eng_stop_done && !reg_wr) |=> sto_q);
   assert_sstop_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_rst && !reg_wr) |=> (!sto_q && !slave_rst));
endmodule

// File: rtl/twi_ctrl_unit.sv
module twi_ctrl_unit
   import twi_ctrl_pkg::*;
#(
   parameter int unsigned W        = CTL_W,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ctl_wr,
   input  logic [W-1:0] ctl_wdata,
   output logic [W-1:0] ctl_rdata,
   input  logic         dat_wr,
   input  logic         glb_ie,
   input  logic         eng_done,
   input  logic         eng_stop_done,
   input  logic         eng_master,
   input  logic         bus_free,
   input  logic         bus_stop_seen,
   input  logic         ev_own_addr,
   input  logic         ev_gen_call,
   input  logic         gc_enable,
   input  logic         ev_byte_rx,
   output logic         go,
   output logic         scl_hold,
   output logic         bus_oe,
   output logic         start_go,
   output logic         stop_req,
   output logic         slave_rst,
   output logic         ack_drive,
   output logic         irq
);
   generate
      if (W != CTL_W) begin : g_bad_width
         $error("twi_ctrl_unit: register width must be 8");
      end
   endgenerate

   logic ack_en_q, en_q, ie_q;
   logic flag_q, wcol_q, sta_q, sto_q;
   logic ack_cause;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_en_q <= 1'b0;
         en_q     <= 1'b0;
         ie_q     <= 1'b0;
      end else if (ctl_wr) begin
         ack_en_q <= ctl_wdata[B_ACK];
         en_q     <= ctl_wdata[B_EN];
         ie_q     <= ctl_wdata[B_IE];
      end
   end

   twi_flag_unit #(.SET_WINS(SET_WINS)) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en_q),
      .hw_done(eng_done),
      .clr_wr (ctl_wr & ctl_wdata[B_FLAG]),
      .dat_wr (dat_wr),
      .flag_q (flag_q),
      .wcol_q (wcol_q),
      .go_q   (go)
   );

   twi_cmd_unit u_cmd (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (en_q),
      .reg_wr       (ctl_wr),
      .wr_sta       (ctl_wdata[B_STA]),
      .wr_sto       (ctl_wdata[B_STO]),
      .bus_free     (bus_free),
      .bus_stop_seen(bus_stop_seen),
      .eng_master   (eng_master),
      .eng_stop_done(eng_stop_done),
      .sta_q        (sta_q),
      .sto_q        (sto_q),
      .start_go     (start_go),
      .stop_req     (stop_req),
      .slave_rst    (slave_rst)
   );

   assign ack_cause = ev_own_addr | (ev_gen_call & gc_enable) | ev_byte_rx;
   assign ack_drive = en_q & ack_en_q & ack_cause;
   assign scl_hold  = en_q & flag_q;
   assign bus_oe    = en_q;
   assign irq       = flag_q & ie_q & glb_ie;

   always_comb begin
      ctl_rdata         = '0;
      ctl_rdata[B_FLAG] = flag_q;
      ctl_rdata[B_ACK]  = ack_en_q;
      ctl_rdata[B_STA]  = sta_q;
      ctl_rdata[B_STO]  = sto_q;
      ctl_rdata[B_WCOL] = wcol_q;
      ctl_rdata[B_EN]   = en_q;
      ctl_rdata[B_RSV]  = 1'b0;
      ctl_rdata[B_IE]   = ie_q;
   end

   assert_ack_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_wdata[B_ACK]) |=> !ack_drive);
   assert_irq_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && en_q && ie_q && glb_ie && !ctl_wr) |=> (irq || !glb_ie));
   assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_wdata[B_EN]) |=> (!bus_oe && !scl_hold && !start_go));
endmodule

// File: tb/tb_twi_ctrl_unit.sv
module tb_twi_ctrl_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic [7:0] ctl_rdata;
   logic dat_wr = 0, glb_ie = 0, eng_done = 0, eng_stop_done = 0;
   logic eng_master = 0, bus_free = 0, bus_stop_seen = 0;
   logic ev_own_addr = 0, ev_gen_call = 0, gc_enable = 0, ev_byte_rx = 0;
   logic go, scl_hold, bus_oe, start_go, stop_req, slave_rst, ack_drive, irq;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   twi_ctrl_unit dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .dat_wr(dat_wr), .glb_ie(glb_ie),
      .eng_done(eng_done), .eng_stop_done(eng_stop_done),
      .eng_master(eng_master), .bus_free(bus_free),
      .bus_stop_seen(bus_stop_seen), .ev_own_addr(ev_own_addr),
      .ev_gen_call(ev_gen_call), .gc_enable(gc_enable),
      .ev_byte_rx(ev_byte_rx), .go(go), .scl_hold(scl_hold),
      .bus_oe(bus_oe), .start_go(start_go), .stop_req(stop_req),
      .slave_rst(slave_rst), .ack_drive(ack_drive), .irq(irq)
   );

   // {ack_en, own_addr, gen_call, gc_enable, byte_rx, expected ack}
   localparam logic [5:0] ACK_VEC [8] = '{
      6'b1_1000_1, 6'b1_0100_0, 6'b1_0110_1, 6'b1_0001_1,
      6'b0_1000_0, 6'b0_0001_0, 6'b0_0110_0, 6'b1_0000_0
   };

   task automatic chk(input string req, input logic [7:0] act,
                      input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      ctl_wr = 1'b1;
      ctl_wdata = v;
      tick();
      ctl_wr = 1'b0;
   endtask

   task automatic pulse_done();
      eng_done = 1'b1;
      tick();
      eng_done = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual %h expected %h", 8'h00, 8'h01);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      chk("R1 rdata", ctl_rdata, 8'h00);
      chk("R1 outs", {go, scl_hold, bus_oe, start_go, stop_req, slave_rst,
                      ack_drive, irq}, 8'h00);
      rst_n = 1'b1;
      tick();
      chk("R1 after release", ctl_rdata, 8'h00);

      // table walk: acknowledge decisions (R10)
      foreach (ACK_VEC[i]) begin
         wr_ctl(ACK_VEC[i][5] ? 8'h44 : 8'h04);
         ev_own_addr = ACK_VEC[i][4];
         ev_gen_call = ACK_VEC[i][3];
         gc_enable   = ACK_VEC[i][2];
         ev_byte_rx  = ACK_VEC[i][1];
         #1;
         chk("R10 ack table", {7'd0, ack_drive}, {7'd0, ACK_VEC[i][0]});
         ev_own_addr = 0; ev_gen_call = 0; gc_enable = 0; ev_byte_rx = 0;
      end

      // R2 layout, reserved and collision bits not writable
      wr_ctl(8'hCF);
      chk("R2 readback", ctl_rdata, 8'h45);
      chk("R11 bus_oe on", {7'd0, bus_oe}, 8'h01);

      // R3 flag set, sticky; R5 hold; R12 irq
      pulse_done();
      chk("R3 flag set", ctl_rdata, 8'hC5);
      chk("R5 hold while flag", {7'd0, scl_hold}, 8'h01);
      chk("R12 irq no global", {7'd0, irq}, 8'h00);
      glb_ie = 1'b1;
      #1;
      chk("R12 irq all set", {7'd0, irq}, 8'h01);
      wr_ctl(8'h44);
      chk("R3 write zero keeps flag", ctl_rdata, 8'hC4);
      chk("R12 irq ie clear", {7'd0, irq}, 8'h00);

      // R6 data write with flag high leaves collision clear
      dat_wr = 1'b1; tick(); dat_wr = 1'b0;
      chk("R6 no collision", {7'd0, ctl_rdata[3]}, 8'h00);

      // R4 hardware set wins over clearing write
      ctl_wr = 1'b1; ctl_wdata = 8'hC4; eng_done = 1'b1;
      tick();
      ctl_wr = 1'b0; eng_done = 1'b0;
      chk("R4 set wins flag", {7'd0, ctl_rdata[7]}, 8'h01);
      chk("R4 set wins no go", {7'd0, go}, 8'h00);

      // R4 clear and go pulse
      wr_ctl(8'hC4);
      chk("R4 flag cleared", ctl_rdata, 8'h44);
      chk("R4 go high", {7'd0, go}, 8'h01);
      chk("R5 hold released", {7'd0, scl_hold}, 8'h00);
      tick();
      chk("R4 go single", {7'd0, go}, 8'h00);

      // R6 collision set, unaffected by control write, then cleared
      dat_wr = 1'b1; tick(); dat_wr = 1'b0;
      chk("R6 collision set", ctl_rdata, 8'h4C);
      wr_ctl(8'h44);
      chk("R2 collision read-only", {7'd0, ctl_rdata[3]}, 8'h01);
      pulse_done();
      dat_wr = 1'b1; tick(); dat_wr = 1'b0;
      chk("R6 collision cleared", {7'd0, ctl_rdata[3]}, 8'h00);
      wr_ctl(8'hC4);

      // R7 start with bus free
      bus_free = 1'b1;
      wr_ctl(8'h64);
      chk("R7 start free", {7'd0, start_go}, 8'h01);
      tick();
      chk("R7 start once", {7'd0, start_go}, 8'h00);
      wr_ctl(8'h44);
      tick();

      // R7 start with bus busy waits for STOP
      bus_free = 1'b0;
      wr_ctl(8'h64);
      chk("R7 busy no start", {7'd0, start_go}, 8'h00);
      tick();
      bus_free = 1'b1;
      #1;
      chk("R7 free without stop", {7'd0, start_go}, 8'h00);
      tick();
      bus_stop_seen = 1'b1;
      #1;
      chk("R7 start on stop", {7'd0, start_go}, 8'h01);
      tick();
      bus_stop_seen = 1'b0;
      #1;
      chk("R7 no repeat", {7'd0, start_go}, 8'h00);
      wr_ctl(8'h44);

      // R8 master stop
      eng_master = 1'b1;
      wr_ctl(8'h54);
      chk("R8 stop req", {7'd0, stop_req}, 8'h01);
      tick();
      chk("R8 stop held", {7'd0, ctl_rdata[4]}, 8'h01);
      eng_stop_done = 1'b1; tick(); eng_stop_done = 1'b0;
      chk("R8 stop cleared", {6'd0, ctl_rdata[4], stop_req}, 8'h00);

      // R9 slave stop
      eng_master = 1'b0;
      wr_ctl(8'h54);
      chk("R9 slave reset", {6'd0, slave_rst, stop_req}, 8'h02);
      tick();
      chk("R9 bit cleared", {6'd0, ctl_rdata[4], slave_rst}, 8'h00);

      // R11 interface disabled
      wr_ctl(8'h40);
      chk("R11 bus_oe off", {7'd0, bus_oe}, 8'h00);
      pulse_done();
      chk("R11 done ignored", {7'd0, ctl_rdata[7]}, 8'h00);
      ev_own_addr = 1'b1; ev_byte_rx = 1'b1;
      #1;
      chk("R11 no ack", {7'd0, ack_drive}, 8'h00);
      ev_own_addr = 1'b0; ev_byte_rx = 1'b0;
      bus_free = 1'b1;
      wr_ctl(8'h60);
      chk("R11 no start", {7'd0, start_go}, 8'h00);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule